// File: doc/BRIEF.md
# Framebuffer Write-Path Logic Unit

This unit sits between a CPU and a video bitmap RAM and can change a CPU byte on its way into the bitmap. The CPU writes the bitmap through one of two address windows of equal size. A write to the plain window goes straight through to RAM. A write to the transform window, which lies one window size above the plain one, takes two clock cycles. In the first cycle the unit reads the old RAM byte at the matching plain offset. The CPU byte is shifted right, with the bits of the previous transform write coming in from the left, and it may be bit-reversed. The result is combined with the old byte by one of sixteen boolean functions. In the second cycle the result is written back to RAM.

An 8-bit configuration register selects the shift amount, the reversal and the function. A sticky overlap flag records any transform write in which the new pixels (after shift and reversal) hit pixels already set in RAM. This lets software detect collisions between drawn objects. The flag is read as the top bit of a status byte and is cleared by that read.

Top module: `pxw_rmw_unit`

## Requirements
- R1: The configuration register is loaded from `cpu_wdata` while `cfg_we` is high. Bits 2:0 give the shift amount (0..7), bit 3 enables bit reversal and bits 7:4 select the function code.
- R2: With A the transformed CPU byte and B the old RAM byte, the function codes give: 0 A, 1 A|B, 2 A|~B, 3 all ones, 4 A&B, 5 B, 6 ~(A^B), 7 ~A|B, 8 A&~B, 9 A^B, 10 ~B, 11 ~(A&B), 12 zero, 13 ~A&B, 14 ~(A|B), 15 ~A.
- R3: With shift amount s, the shifted byte is bits [7+s:s] of the 16-bit value {P, D}. D is the CPU byte and P is the byte of the previous transform-window write. Writes to the plain window leave P unchanged.
- R4: When reversal is enabled, bit i of the shifted byte moves to bit 7-i before the function is applied.
- R5: A CPU write to the transform window (`cpu_addr[15:13]` = 3) drives `ram_addr` with `cpu_addr[12:0]` and keeps `ram_we` low in that cycle. In the next cycle it drives `ram_we` high with the same `ram_addr` and the function result on `ram_wdata`.
- R6: A CPU write to the plain window (`cpu_addr[15:13]` = 2) drives `ram_we` high in the same cycle, with `ram_addr` = `cpu_addr[12:0]` and `ram_wdata` = `cpu_wdata` unmodified.
- R7: A CPU write to an address outside both windows raises `ram_we` neither in that cycle nor in the next.
- R8: When a transform write has (A & B) nonzero, the overlap flag is set from the next cycle onward and stays set until it is cleared. `stat_rdata` carries the flag in bit 7 and zero in bits 6:0.
- R9: A cycle with `stat_re` high clears the flag at the next clock edge. If a transform write in that same cycle has an overlap, setting takes priority and the flag stays set.
- R10: After reset the configuration register, the held previous byte and the flag are all zero, and `ram_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe for a bitmap window |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data (also the configuration value) |
| cfg_we | input | 1 | Load the configuration register from `cpu_wdata` |
| stat_re | input | 1 | Status read strobe; clears the overlap flag |
| stat_rdata | output | 8 | Status byte, overlap flag in bit 7 |
| ram_addr | output | 13 | Bitmap RAM byte offset |
| ram_we | output | 1 | Bitmap RAM write enable |
| ram_wdata | output | 8 | Bitmap RAM write data |
| ram_rdata | input | 8 | Bitmap RAM read data, combinational from `ram_addr` |

## Verification
The held state of this unit shows up at the ports without delay. A wrong held previous byte corrupts the very next transform write whenever the shift amount is nonzero. A wrong configuration register shows in the `ram_wdata` of the first transform write after it is loaded. A wrong pending-write address or data appears on the RAM port one cycle after the read phase. A flag that fails to set, stick or clear shows on the next status read. For this reason the bench sweeps every function, shift amount and reversal setting, and checks each write-back as well as each status read.

// File: rtl/pxw_pkg.sv
package pxw_pkg;

    localparam int unsigned PXW_DW = 8;
    localparam int unsigned PXW_SW = 3;

    // Configuration register layout: the field positions are part of the CPU view.
    typedef struct packed {
        logic [3:0]        fn;
        logic              flop;
        logic [PXW_SW-1:0] shamt;
    } pxw_cfg_t;

endpackage

// File: rtl/pxw_shifter.sv
module pxw_shifter #(
    parameter int unsigned W  = 8,
    parameter int unsigned SW = 3
) (
    input  logic [W-1:0]  carry_in,
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] shamt,
    input  logic          flop,
    output logic [W-1:0]  dout
);

    logic [2*W-1:0] wide;
    logic [W-1:0]   shifted;

    always_comb begin
        wide    = {carry_in, din} >> shamt;
        shifted = wide[W-1:0];
    end

    // Reversal is a fixed wiring choice per bit, picked by flop.
    for (genvar i = 0; i < int'(W); i++) begin : g_rev
        assign dout[i] = flop ? shifted[W-1-i] : shifted[i];
    end

endmodule

// File: rtl/pxw_logic.sv
module pxw_logic #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fn,
    output logic [W-1:0] y,
    output logic         overlap
);

    always_comb begin
        case (fn)
            4'd0:    y = a;
            4'd1:    y = a | b;
            4'd2:    y = a | ~b;
            4'd3:    y = '1;
            4'd4:    y = a & b;
            4'd5:    y = b;
            4'd6:    y = ~(a ^ b);
            4'd7:    y = ~a | b;
            4'd8:    y = a & ~b;
            4'd9:    y = a ^ b;
            4'd10:   y = ~b;
            4'd11:   y = ~(a & b);
            4'd12:   y = '0;
            4'd13:   y = ~a & b;
            4'd14:   y = ~(a | b);
            default: y = ~a;
        endcase
        overlap = |(a & b);
    end

endmodule

// File: rtl/pxw_rmw_unit.sv
module pxw_rmw_unit #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned OFS_W      = 13,
    parameter logic [15:0] PLAIN_BASE = 16'h4000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [pxw_pkg::PXW_DW-1:0] cpu_wdata,
    input  logic                      cfg_we,
    input  logic                      stat_re,
    output logic [pxw_pkg::PXW_DW-1:0] stat_rdata,
    output logic [OFS_W-1:0]          ram_addr,
    output logic                      ram_we,
    output logic [pxw_pkg::PXW_DW-1:0] ram_wdata,
    input  logic [pxw_pkg::PXW_DW-1:0] ram_rdata
);
    import pxw_pkg::*;

    localparam int unsigned   SEL_W     = ADDR_W - OFS_W;
    localparam logic [SEL_W-1:0] PLAIN_SEL = PLAIN_BASE[ADDR_W-1:OFS_W];
    localparam logic [SEL_W-1:0] XFORM_SEL = PLAIN_SEL + SEL_W'(1);

    typedef struct packed {
        pxw_cfg_t           cfg;
        logic [PXW_DW-1:0]  prev;
        logic               pend;
        logic [OFS_W-1:0]   addr;
        logic [PXW_DW-1:0]  wdata;
        logic               hit;
    } st_t;

    st_t st_d, st_q;

    logic              sel_plain, sel_xform, xform_go;
    logic [PXW_DW-1:0] shaped, fn_out;
    logic              overlap;

    pxw_shifter #(.W(PXW_DW), .SW(PXW_SW)) u_shift (
        .carry_in (st_q.prev),
        .din      (cpu_wdata),
        .shamt    (st_q.cfg.shamt),
        .flop     (st_q.cfg.flop),
        .dout     (shaped)
    );

    pxw_logic #(.W(PXW_DW)) u_fn (
        .a       (shaped),
        .b       (ram_rdata),
        .fn      (st_q.cfg.fn),
        .y       (fn_out),
        .overlap (overlap)
    );

    always_comb begin
        sel_plain = cpu_we && (cpu_addr[ADDR_W-1:OFS_W] == PLAIN_SEL);
        sel_xform = cpu_we && (cpu_addr[ADDR_W-1:OFS_W] == XFORM_SEL);
        xform_go  = sel_xform && !st_q.pend;

        st_d      = st_q;
        st_d.pend = xform_go;
        if (cfg_we) begin
            st_d.cfg = pxw_cfg_t'(cpu_wdata);
        end
        if (xform_go) begin
            st_d.prev  = cpu_wdata;
            st_d.addr  = cpu_addr[OFS_W-1:0];
            st_d.wdata = fn_out;
        end
        if (stat_re) begin
            st_d.hit = 1'b0;
        end
        if (xform_go && overlap) begin
            st_d.hit = 1'b1;
        end

        // RAM port: a pending write-back owns the port for its cycle.
        if (st_q.pend) begin
            ram_addr  = st_q.addr;
            ram_we    = 1'b1;
            ram_wdata = st_q.wdata;
        end else begin
            ram_addr  = cpu_addr[OFS_W-1:0];
            ram_we    = sel_plain;
            ram_wdata = cpu_wdata;
        end

        stat_rdata = {st_q.hit, {(PXW_DW-1){1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: read phase keeps the RAM write off, write-back follows at the same offset
    a_r5_read_phase: assert property (@(posedge clk) disable iff (!rst_n)
        xform_go |-> !ram_we);
    a_r5_write_back: assert property (@(posedge clk) disable iff (!rst_n)
        xform_go |=> (ram_we && ram_addr == $past(cpu_addr[OFS_W-1:0])));

    // R6: plain window writes pass through untouched
    a_r6_plain_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_plain && !st_q.pend) |-> (ram_we && ram_wdata == cpu_wdata));

    // R7: no RAM write without a window hit or pending write-back
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && !sel_plain) |-> !ram_we);

    // R8: an overlapping transform write raises the flag
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (xform_go && |(shaped & ram_rdata)) |=> stat_rdata[PXW_DW-1]);

    // R9: a status read with no new overlap clears the flag
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_re && !(xform_go && overlap)) |=> !stat_rdata[PXW_DW-1]);

endmodule

// File: tb/sim_pxw_rmw_unit.sv
`timescale 1ns/1ps
module sim_pxw_rmw_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_we, cfg_we, stat_re;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  stat_rdata;
    logic [12:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata, ram_rdata;

    int checks = 0;
    int failures = 0;

    logic [7:0] mem [256];
    logic [7:0] cfg_exp;
    logic [7:0] prev_exp;
    logic       flag_exp;

    always #10 clk = ~clk;

    pxw_rmw_unit u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cfg_we(cfg_we), .stat_re(stat_re),
        .stat_rdata(stat_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Bitmap RAM model: asynchronous read, synchronous write.
    assign ram_rdata = mem[ram_addr[7:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
        end else if (ram_we) begin
            mem[ram_addr[7:0]] <= ram_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Truth table per code, indexed by {a,b}.
    function automatic logic [3:0] truth(input logic [3:0] fn);
        case (fn)
            4'd0: return 4'b1100;  4'd1: return 4'b1110;
            4'd2: return 4'b1101;  4'd3: return 4'b1111;
            4'd4: return 4'b1000;  4'd5: return 4'b1010;
            4'd6: return 4'b1001;  4'd7: return 4'b1011;
            4'd8: return 4'b0100;  4'd9: return 4'b0110;
            4'd10: return 4'b0101; 4'd11: return 4'b0111;
            4'd12: return 4'b0000; 4'd13: return 4'b0010;
            4'd14: return 4'b0001; default: return 4'b0011;
        endcase
    endfunction

    task automatic set_cfg(input logic [7:0] v);
        cfg_we = 1'b1;
        cpu_wdata = v;
        tick();
        cfg_we = 1'b0;
        cfg_exp = v;
    endtask

    task automatic xwrite(input logic [12:0] ofs, input logic [7:0] d,
                          input bit with_read, input string req);
        logic [7:0]  b, a, sh, y;
        logic [3:0]  tt;
        logic [15:0] cat;
        b   = mem[ofs[7:0]];
        cat = ({prev_exp, d} >> cfg_exp[2:0]);
        sh  = cat[7:0];
        for (int i = 0; i < 8; i++) a[i] = cfg_exp[3] ? sh[7-i] : sh[i];
        tt  = truth(cfg_exp[7:4]);
        for (int i = 0; i < 8; i++) y[i] = tt[{a[i], b[i]}];

        cpu_we = 1'b1;
        cpu_addr = 16'h6000 | 16'(ofs);
        cpu_wdata = d;
        stat_re = with_read;
        @(negedge clk);
        chk(ram_we == 1'b0, "R5", "read phase we", int'(ram_we), 0);
        chk(ram_addr == ofs, "R5", "read phase addr", int'(ram_addr), int'(ofs));
        tick();
        cpu_we = 1'b0;
        stat_re = 1'b0;
        @(negedge clk);
        chk(ram_we == 1'b1 && ram_addr == ofs, "R5", "write-back addr",
            int'(ram_addr), int'(ofs));
        chk(ram_wdata == y, req, "write-back data", int'(ram_wdata), int'(y));
        tick();
        prev_exp = d;
        if (with_read) flag_exp = 1'b0;
        if ((a & b) != 8'h00) flag_exp = 1'b1;
    endtask

    task automatic stat_read(input logic exp, input string req);
        stat_re = 1'b1;
        @(negedge clk);
        chk(stat_rdata == {exp, 7'b0}, req, "status", int'(stat_rdata), int'({exp, 7'b0}));
        tick();
        stat_re = 1'b0;
        flag_exp = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_we = 1'b0; cfg_we = 1'b0; stat_re = 1'b0;
        cpu_addr = '0; cpu_wdata = '0;
        cfg_exp = '0; prev_exp = '0; flag_exp = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_rdata == 8'h00, "R10", "reset status", int'(stat_rdata), 0);
        chk(ram_we == 1'b0, "R10", "reset ram_we", int'(ram_we), 0);
        tick();

        // R10: held byte is zero after reset; shift 7 brings in its zero bits
        set_cfg(8'h07);
        xwrite(13'd10, 8'hFF, 1'b0, "R10 prev cleared");
        chk(mem[10] == 8'h01, "R10", "mem after shift", int'(mem[10]), 1);
        stat_read(flag_exp, "R8");

        // R6: plain write passes unmodified
        cpu_we = 1'b1; cpu_addr = 16'h4014; cpu_wdata = 8'h5A;
        @(negedge clk);
        chk(ram_we && ram_addr == 13'h14 && ram_wdata == 8'h5A, "R6", "plain write",
            int'(ram_wdata), 8'h5A);
        tick();
        cpu_we = 1'b0;
        // R3: the plain write must not have replaced the held byte
        set_cfg(8'h04);
        xwrite(13'd11, 8'h3C, 1'b0, "R3 plain keeps prev");

        // R7: outside both windows
        cpu_we = 1'b1; cpu_addr = 16'h8014; cpu_wdata = 8'hAA;
        @(negedge clk);
        chk(ram_we == 1'b0, "R7", "high window we", int'(ram_we), 0);
        tick();
        cpu_addr = 16'h2014;
        @(negedge clk);
        chk(ram_we == 1'b0, "R7", "low window we", int'(ram_we), 0);
        tick();
        cpu_we = 1'b0;
        @(negedge clk);
        chk(ram_we == 1'b0 && mem[20] == 8'h5A, "R7", "no later write",
            int'(mem[20]), 8'h5A);
        tick();
        stat_read(flag_exp, "R8");

        // R1 R2 R3 R4: sweep of every function, reversal and shift
        for (int fn = 0; fn < 16; fn++) begin
            for (int fl = 0; fl < 2; fl++) begin
                for (int s = 0; s < 8; s++) begin
                    set_cfg({4'(fn), 1'(fl), 3'(s)});
                    for (int k = 0; k < 2; k++) begin
                        xwrite(13'(64 + ((fn * 32 + fl * 16 + s * 2 + k) & 127)),
                               8'(fn * 29 + s * 11 + fl * 67 + k * 113 + 3),
                               1'b0, "R1 R2 R3 R4");
                    end
                    stat_read(flag_exp, "R8 sweep");
                end
            end
        end

        // R8: flag is sticky across a non-overlapping write
        set_cfg(8'h00);
        xwrite(13'd30, 8'hFF, 1'b0, "R2");
        xwrite(13'd31, 8'h00, 1'b0, "R2");
        stat_read(1'b1, "R8 sticky");
        // R9: the read cleared it
        stat_read(1'b0, "R9 cleared");
        // R9: set wins over a read in the same cycle
        xwrite(13'd32, 8'hFF, 1'b1, "R2");
        stat_read(1'b1, "R9 set wins");
        stat_read(1'b0, "R9 cleared again");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule